// File: doc/BRIEF.md
# Mailbox Receive FIFO with Raw Pointer Status

This block is the receiving side of an inter-processor mailbox. Remote cores push messages through a valid/ready port. Each message is a 64-bit payload tagged with a source channel id. Messages are held in a circular FIFO. Software drains the FIFO over a simple 32-bit register bus. It reads the entry at the head of the queue as an id word, a low payload word and a high payload word. It then writes a trigger register to release that entry.

The status word does not report an occupancy count. It exposes the raw write pointer, the raw read pointer and a full bit. Equal pointers are ambiguous: they mean a full FIFO when the full bit is set and an empty FIFO when it is clear. Software derives the occupancy from these three fields. A sticky not-empty interrupt, gated by a mask bit, tells software that messages are waiting. A flush register clears the queue, and a depth register reports the capacity.

Register offsets (byte addresses on `reg_addr_i`):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read | channel id of the head entry |
| 0x04 | read | payload bits 31:0 of the head entry |
| 0x08 | read | payload bits 63:32 of the head entry |
| 0x0C | write | bit 0 = 1 releases the head entry |
| 0x10 | write | writing 0 flushes the FIFO |
| 0x14 | read | full bit, write pointer, read pointer |
| 0x18 | read/write | bit 0 = pending interrupt; write 1 to clear |
| 0x1C | read/write | interrupt mask, bits 4:0 |
| 0x24 | read | FIFO capacity minus one |

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the status word (0x14) reads 0, the interrupt status (0x18) reads 0, the mask (0x1C) reads 0x1F, irq_o is low and push_ready_o is high.
- R2: The register at offset 0x24 reads DEPTH-1.
- R3: An accepted push (push_valid_i and push_ready_o both high at a clock edge) stores the entry at the write pointer and advances that pointer by one, modulo DEPTH. The status word at 0x14 carries the full bit in bit 0, the write pointer in bits [23:16] and the read pointer in bits [31:24]. All other bits read 0.
- R4: Offset 0x00 returns the head entry's channel id, zero-extended. Offset 0x04 returns payload bits [31:0] and offset 0x08 returns payload bits [63:32]. Entries come out in push order. All three registers read 0 while the FIFO is empty.
- R5: A write to offset 0x0C with bit 0 set advances the read pointer by one, modulo DEPTH. The same write has no effect on the pointers or the full bit while the FIFO is empty.
- R6: The full bit sets when a push without a simultaneous pop makes the two pointers equal. While the bit is set, push_ready_o is low, and a push is dropped without moving either pointer.
- R7: The FIFO holds DEPTH entries when the pointers are equal and the full bit is set, and none when the bit is clear. It holds write minus read entries when the write pointer is ahead of the read pointer, and DEPTH minus read plus write entries otherwise.
- R8: Writing 0 to offset 0x10 clears both pointers and the full bit. Writing any nonzero value there has no effect.
- R9: Interrupt status bit 0 becomes 1 on the clock edge after an edge at which the FIFO is non-empty, and it holds until software writes 1 to bit 0 of offset 0x18. That write clears the bit, and the bit sets again on the following edge if entries remain.
- R10: irq_o is high exactly while the pending bit is 1 and mask bit 0 is 0. A write to 0x1C stores bits [4:0], which read back at 0x1C.
- R11: A push and a pop trigger at the same clock edge both take effect. Each pointer advances and the full bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| push_valid_i | input | 1 | remote sender offers an entry |
| push_ready_o | output | 1 | FIFO can accept an entry |
| push_id_i | input | ID_W | source channel id of the offered entry |
| push_data_i | input | 64 | payload of the offered entry |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 8 | register byte offset |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data (combinational on the address) |
| irq_o | output | 1 | masked not-empty interrupt |

## Verification
The bench fills the FIFO past capacity starting from a non-zero pointer. A design that let the extra push through would overwrite the oldest entry and report a wrong head, and the full bit would be missing when the pointers wrap onto each other. The bench then reads the status word with the write pointer behind the read pointer. Any error in pointer wrap shows up as an occupancy that disagrees with the scoreboard queue. Several cases are aimed at pointer side effects that a looser design would show:
- A pop trigger while empty would push the read pointer past the write pointer.
- A simultaneous push and pop that touched the full bit would report a bogus full state.
- A non-zero write to the flush register that still flushed would silently lose queued messages.

The interrupt is cleared while entries remain, and it must read low for exactly one cycle and then return. It is also cleared after a drain, and it must then stay low.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam int MSG_W  = 64;
  localparam int MASK_W = 5;
  localparam int PTR_FIELD_W = 8;

  localparam logic [ADDR_W-1:0] OFS_HEAD_ID = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_HEAD_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_HEAD_HI = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_POP     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLUSH   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ISTAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IMASK   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH   = 8'h24;

  typedef struct packed {
    logic pop;
    logic flush;
    logic irq_clr;
    logic mask_we;
  } reg_cmd_t;
endpackage

// File: rtl/mbox_rx_store.sv
module mbox_rx_store #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int MSG_W = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [ID_W-1:0]  push_id_i,
  input  logic [MSG_W-1:0] push_data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic             push_ready_o,
  output logic [ID_W-1:0]  head_id_o,
  output logic [MSG_W-1:0] head_data_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [MSG_W-1:0] mem_data [DEPTH];
  logic [ID_W-1:0]  mem_id   [DEPTH];
  logic [AW-1:0]    wr_q, rd_q, wr_nxt, rd_nxt;
  logic             full_q, push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_nxt       = step(wr_q);
  assign rd_nxt       = step(rd_q);
  assign empty_o      = (wr_q == rd_q) && !full_q;
  assign push_ready_o = !full_q && !flush_i;
  assign push_ok      = push_valid_i && push_ready_o;
  assign pop_ok       = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else if (flush_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_nxt;
      if (pop_ok)  rd_q <= rd_nxt;
      if (push_ok && !pop_ok && (wr_nxt == rd_q)) full_q <= 1'b1;
      else if (pop_ok && !push_ok)                full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      mem_data[wr_q] <= push_data_i;
      mem_id[wr_q]   <= push_id_i;
    end
  end

  assign head_data_o = mem_data[rd_q];
  assign head_id_o   = mem_id[rd_q];
  assign wr_ptr_o    = wr_q;
  assign rd_ptr_o    = rd_q;
  assign full_o      = full_q;
endmodule

// File: rtl/mbox_rx_irq.sv
module mbox_rx_irq #(
  parameter int MASK_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              not_empty_i,
  input  logic              clr_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic              pend_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              irq_o
);
  logic              pend_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= '1;
    end else begin
      // clear wins for one edge; level re-arms it afterwards
      pend_q <= clr_i ? 1'b0 : (pend_q | not_empty_i);
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = pend_q & ~mask_q[0];
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [MSG_W-1:0]  push_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  reg_cmd_t          cmd;
  logic [ID_W-1:0]   head_id;
  logic [MSG_W-1:0]  head_data;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, empty, irq_pend;
  logic [MASK_W-1:0] irq_mask;

  always_comb begin
    cmd.pop     = reg_we_i && (reg_addr_i == OFS_POP)   && reg_wdata_i[0];
    cmd.flush   = reg_we_i && (reg_addr_i == OFS_FLUSH) && (reg_wdata_i == '0);
    cmd.irq_clr = reg_we_i && (reg_addr_i == OFS_ISTAT) && reg_wdata_i[0];
    cmd.mask_we = reg_we_i && (reg_addr_i == OFS_IMASK);
  end

  mbox_rx_store #(.DEPTH(DEPTH), .ID_W(ID_W), .MSG_W(MSG_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_valid_i(push_valid_i),
    .push_id_i   (push_id_i),
    .push_data_i (push_data_i),
    .pop_i       (cmd.pop),
    .flush_i     (cmd.flush),
    .push_ready_o(push_ready_o),
    .head_id_o   (head_id),
    .head_data_o (head_data),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .full_o      (full),
    .empty_o     (empty)
  );

  mbox_rx_irq #(.MASK_W(MASK_W)) i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .not_empty_i (!empty),
    .clr_i       (cmd.irq_clr),
    .mask_we_i   (cmd.mask_we),
    .mask_wdata_i(reg_wdata_i[MASK_W-1:0]),
    .pend_o      (irq_pend),
    .mask_o      (irq_mask),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_HEAD_ID: reg_rdata_o = empty ? '0 : REG_W'(head_id);
      OFS_HEAD_LO: reg_rdata_o = empty ? '0 : head_data[REG_W-1:0];
      OFS_HEAD_HI: reg_rdata_o = empty ? '0 : head_data[MSG_W-1:REG_W];
      OFS_STAT:    reg_rdata_o = {PTR_FIELD_W'(rd_ptr), PTR_FIELD_W'(wr_ptr),
                                  {(REG_W - 2*PTR_FIELD_W - 1){1'b0}}, full};
      OFS_ISTAT:   reg_rdata_o = REG_W'(irq_pend);
      OFS_IMASK:   reg_rdata_o = REG_W'(irq_mask);
      OFS_DEPTH:   reg_rdata_o = REG_W'(DEPTH - 1);
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_rx_fifo_chk.sv
module mbox_rx_fifo_chk
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_valid_i,
  input logic              push_ready_o,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [AW-1:0]     wr_ptr,
  input logic [AW-1:0]     rd_ptr,
  input logic              full,
  input logic              empty,
  input logic              irq_pend
);
  logic [AW-1:0] wr_step;
  logic          wr_to_pop, wr_to_flush, wr_to_clr;

  assign wr_step     = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  assign wr_to_pop   = reg_we_i && (reg_addr_i == 8'h0C);
  assign wr_to_flush = reg_we_i && (reg_addr_i == 8'h10);
  assign wr_to_clr   = reg_we_i && (reg_addr_i == 8'h18) && reg_wdata_i[0];

  assert_push_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_i && push_ready_o |=> wr_ptr == $past(wr_step));

  assert_empty_pop_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_to_pop && empty |=> (rd_ptr == $past(rd_ptr)) && !full);

  assert_full_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !push_ready_o);

  assert_drop_keeps_ptr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && push_valid_i && !wr_to_flush |=> $stable(wr_ptr));

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_to_flush && (reg_wdata_i == '0) |=> (wr_ptr == '0) && (rd_ptr == '0) && !full);

  assert_pend_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend && !wr_to_clr |=> irq_pend);

  assert_pend_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty && !wr_to_clr |=> irq_pend);
endmodule

bind mbox_rx_fifo mbox_rx_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_valid_i(push_valid_i),
  .push_ready_o(push_ready_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .full        (full),
  .empty       (empty),
  .irq_pend    (irq_pend)
);

// File: tb/test_mbox_rx_fifo.sv
module test_mbox_rx_fifo;
  localparam int DEPTH = 8;
  localparam int ID_W  = 3;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [63:0]     data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_valid_i = 1'b0;
  logic        push_ready_o;
  logic [ID_W-1:0] push_id_i = '0;
  logic [63:0] push_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb_q[$];
  int exp_wr = 0, exp_rd = 0;
  bit exp_full = 1'b0;
  logic [31:0] rd_val;

  always #5 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH), .ID_W(ID_W)) i_mbox_rx_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .push_valid_i(push_valid_i), .push_ready_o(push_ready_o),
    .push_id_i(push_id_i), .push_data_i(push_data_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  function automatic int step(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  // driver: offers one entry, records it when the FIFO accepts it
  task automatic push(input logic [ID_W-1:0] id, input logic [63:0] d);
    @(negedge clk);
    push_valid_i = 1'b1; push_id_i = id; push_data_i = d;
    #1;
    if (push_ready_o) begin
      sb_q.push_back('{id: id, data: d});
      exp_wr = step(exp_wr);
      if (exp_wr == exp_rd) exp_full = 1'b1;
    end
    @(negedge clk);
    push_valid_i = 1'b0;
  endtask

  // monitor: compares the head registers with the scoreboard, then pops
  task automatic drain_one(input string req);
    item_t e;
    logic [31:0] id_v, lo_v, hi_v;
    e = sb_q.pop_front();
    @(negedge clk);
    reg_rd(8'h00, id_v); reg_rd(8'h04, lo_v); reg_rd(8'h08, hi_v);
    check(id_v == 32'(e.id), req, 64'(id_v), 64'(e.id));
    check({hi_v, lo_v} == e.data, req, {hi_v, lo_v}, e.data);
    reg_wr(8'h0C, 32'h1);
    exp_rd = step(exp_rd);
    exp_full = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [31:0] s;
    int w, r, occ;
    @(negedge clk);
    reg_rd(8'h14, s);
    check(s == {8'(exp_rd), 8'(exp_wr), 15'b0, exp_full}, req, 64'(s),
          64'({8'(exp_rd), 8'(exp_wr), 15'b0, exp_full}));
    w = int'(s[23:16]); r = int'(s[31:24]);
    if (w == r)     occ = s[0] ? DEPTH : 0;
    else if (w > r) occ = w - r;
    else            occ = DEPTH - r + w;
    check(occ == sb_q.size(), "R7", 64'(occ), 64'(sb_q.size()));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(8'h14, rd_val); check(rd_val == 0, "R1 status", 64'(rd_val), 0);
    reg_rd(8'h18, rd_val); check(rd_val == 0, "R1 istat", 64'(rd_val), 0);
    reg_rd(8'h1C, rd_val); check(rd_val == 32'h1F, "R1 mask", 64'(rd_val), 64'h1F);
    check(irq_o == 1'b0, "R1 irq", 64'(irq_o), 0);
    check(push_ready_o == 1'b1, "R1 ready", 64'(push_ready_o), 1);
    // R2 depth register
    reg_rd(8'h24, rd_val); check(rd_val == DEPTH - 1, "R2 depth", 64'(rd_val), 64'(DEPTH - 1));
    // R4 empty head reads zero
    reg_rd(8'h04, rd_val); check(rd_val == 0, "R4 empty head", 64'(rd_val), 0);
    // R5 pop while empty
    reg_wr(8'h0C, 32'h1);
    check_status("R5 empty pop");

    // R3 pushes
    push(3'd1, 64'h1111_2222_3333_4444);
    push(3'd2, 64'hAAAA_BBBB_CCCC_DDDD);
    push(3'd5, 64'h0123_4567_89AB_CDEF);
    check_status("R3 status after pushes");

    // R9/R10 interrupt
    reg_rd(8'h18, rd_val); check(rd_val == 1, "R9 pend set", 64'(rd_val), 1);
    check(irq_o == 1'b0, "R10 masked irq", 64'(irq_o), 0);
    reg_wr(8'h1C, 32'h1E);
    reg_rd(8'h1C, rd_val); check(rd_val == 32'h1E, "R10 mask readback", 64'(rd_val), 64'h1E);
    check(irq_o == 1'b1, "R10 unmasked irq", 64'(irq_o), 1);
    reg_wr(8'h18, 32'h1);
    reg_rd(8'h18, rd_val); check(rd_val == 0, "R9 cleared", 64'(rd_val), 0);
    check(irq_o == 1'b0, "R10 irq after clear", 64'(irq_o), 0);
    @(negedge clk);
    reg_rd(8'h18, rd_val); check(rd_val == 1, "R9 re-set", 64'(rd_val), 1);

    // R4 drain in order
    while (sb_q.size() > 0) drain_one("R4 head order");
    check_status("R5 after drain");
    reg_wr(8'h18, 32'h1);
    @(negedge clk);
    reg_rd(8'h18, rd_val); check(rd_val == 0, "R9 stays clear when empty", 64'(rd_val), 0);
    check(irq_o == 1'b0, "R10 irq idle", 64'(irq_o), 0);

    // R6 fill past capacity from a nonzero pointer
    for (int i = 0; i < DEPTH; i++) push(3'(i), {32'hF00D_0000 + 32'(i), 32'(i * 7)});
    check_status("R6 full status");
    check(push_ready_o == 1'b0, "R6 ready low", 64'(push_ready_o), 0);
    push(3'd7, 64'hDEAD_BEEF_DEAD_BEEF);
    check_status("R6 dropped push");

    // R7 wrap: write pointer behind read pointer
    drain_one("R6 head after drop");
    drain_one("R4 head order");
    check_status("R7 wrapped occupancy");

    // R11 simultaneous push and pop
    drain_one("R11 head before");
    begin
      item_t e;
      logic [31:0] lo_v;
      e = sb_q[0];
      @(negedge clk);
      reg_rd(8'h04, lo_v);
      check(lo_v == e.data[31:0], "R11 head", 64'(lo_v), 64'(e.data[31:0]));
      push_valid_i = 1'b1; push_id_i = 3'd6; push_data_i = 64'h5555_6666_7777_8888;
      reg_we_i = 1'b1; reg_addr_i = 8'h0C; reg_wdata_i = 32'h1;
      @(negedge clk);
      push_valid_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
      void'(sb_q.pop_front());
      sb_q.push_back('{id: 3'd6, data: 64'h5555_6666_7777_8888});
      exp_wr = step(exp_wr); exp_rd = step(exp_rd);
    end
    check_status("R11 both advance");

    // R8 flush register
    reg_wr(8'h10, 32'h1);
    check_status("R8 nonzero ignored");
    reg_wr(8'h10, 32'h0);
    sb_q.delete(); exp_wr = 0; exp_rd = 0; exp_full = 1'b0;
    check_status("R8 flush");
    reg_rd(8'h00, rd_val); check(rd_val == 0, "R4 head after flush", 64'(rd_val), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule